// File: doc/BRIEF.md
# External Interrupt Priority Controller

This block holds the configuration register for five interrupt sources and turns raw request inputs into per-source pending flags with priority levels. Three of the sources are external pins, which are active low and may be asynchronous. The other two are internal requesters, a host port and a DMA engine. Each source has a two-bit field that does two jobs: the value zero disables the source, and any non-zero value enables it at a priority of the field minus one.

Each external pin has its own trigger-mode bit:

- In level mode, a request is pending for as long as the synchronized pin stays low.
- In negative-edge mode, a falling transition of the synchronized pin sets a per-pin latch. The latch holds until the consumer pulses that pin's acknowledge line.

Every external slot also has a read-only status bit, and its meaning follows the configuration. When the source is enabled in edge mode, the bit shows the latch. In every other case it shows the synchronized pin, and reads 1 when the pin is low.

The register is written over a single-word write strobe and read back combinationally. The downstream consumer uses the `pend` and `prio_lvl` outputs to arbitrate against its own priority mask and to generate vectors. Those two steps happen outside this block.

Top module: `ext_irq_prio_ctrl`

## Requirements
- R1: After hardware reset, `rd_data` reads 0 with all pins high, and `pend` and `prio_lvl` are 0.
- R2: A one-cycle `sw_rst` pulse clears every writable register bit and every edge latch. From the next cycle `pend` is 0, and it takes priority over a write in the same cycle.
- R3: Level field encoding: 00 disables the source, while 01, 10 and 11 enable it at levels 0, 1 and 2. For a pending source, `prio_lvl` equals the field minus one.
- R4: Register layout, per external pin i (A=0, B=1, C=2), with base = 4i:
  - bits base+1:base hold the level field;
  - bit base+2 holds the trigger mode (0 = level, 1 = negative edge);
  - bit base+3 holds the status bit.

  Bits 13:12 hold the host level field and bits 15:14 hold the DMA level field. Written fields read back unchanged.
- R5: Status bits are read-only. A write of 1 to bit 3, 7 or 11 leaves the status unchanged.
- R6: In level mode with the source enabled, the source is pending and its status reads 1 two clock edges after the pin goes low. Both clear two edges after the pin returns high.
- R7: In edge mode with the source enabled, a synchronized falling edge sets the latch. The source then stays pending, and its status reads 1, after the pin returns high.
- R8: An acknowledge pulse clears that pin's latch. If a new falling edge is detected in the same cycle, the latch stays set.
- R9: Disabling a source, or switching it to level mode, clears its latch. Re-enabling edge mode afterwards does not bring the request back.
- R10: A disabled source is never pending, and its status bit shows the synchronized pin (1 when low) in either mode.
- R11: Host and DMA are pending exactly when their request input is high and their field is non-zero.
- R12: `prio_lvl` is 0 for every source that is not pending and never carries the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset command, one-cycle pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data with live status bits |
| irq_pin_n | input | 3 | External request pins, active low, asynchronous |
| ack_ext | input | 3 | Service acknowledge per external pin |
| int_req | input | 2 | Internal requests: bit 0 host, bit 1 DMA |
| pend | output | 5 | Pending flags: A, B, C, host, DMA |
| prio_lvl | output | 10 | Two-bit priority per source, same order |

## Verification
The assertions assume the following about the inputs:
- `sw_rst` and `ack_ext` are single-cycle pulses.
- The pins hold each value for several cycles, so every transition reaches the synchronizer output.
- `int_req` is already synchronous to `clk`.

The stimulus changes every input only on the falling clock edge. It holds each pin level for at least four cycles and drives the acknowledge only for one cycle. The one deliberate overlap is an acknowledge in the exact cycle a fresh falling edge reaches the latch, which exercises the set-wins rule.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared widths and helpers for the interrupt priority controller.
// Assumes the per-pin register slot is four bits and a level field is two bits.
package irq_ctrl_pkg;

    localparam int LVL_W  = 2;
    localparam int SLOT_W = 4;

    localparam int SLOT_MODE_BIT = 2;
    localparam int SLOT_STAT_BIT = 3;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_mode_e;

    // Map a level field to the priority it grants, zero when disabled.
    function automatic logic [LVL_W-1:0] field_to_prio(input logic [LVL_W-1:0] fld);
        return (fld == '0) ? '0 : fld - 1'b1;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Multi-flop synchronizer for one asynchronous input.
// Assumes STAGES >= 2. Reset loads RST_VAL, which is the idle level of the input.
module irq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] shift_q;

    // Shift the raw input through the synchronizing chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= {STAGES{RST_VAL}};
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
        end
    end

    assign dout = shift_q[STAGES-1];

endmodule

// File: rtl/irq_ext_chan.sv
// Module: irq_ext_chan
// Handles one external request pin: synchronization, falling-edge latch,
// pending decode and status bit.
// Assumes the pin is active low and idles high. The acknowledge is a one-cycle pulse.
module irq_ext_chan
    import irq_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             pin_n,
    input  logic [LVL_W-1:0] lvl_fld,
    input  trig_mode_e       mode,
    input  logic             ack,
    output logic             pend,
    output logic             status
);

    logic pin_s;
    logic pin_prev_q;
    logic latch_q;
    logic enabled;
    logic edge_armed;
    logic fall_det;
    logic pin_low;

    irq_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_n),
        .dout (pin_s)
    );

    assign enabled    = (lvl_fld != '0);
    assign edge_armed = enabled && (mode == TRIG_FALL);
    assign pin_low    = ~pin_s;
    assign fall_det   = pin_prev_q && !pin_s;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev_q <= 1'b1;
        end else begin
            pin_prev_q <= pin_s;
        end
    end

    // Edge latch: a new edge has priority over an acknowledge; cleared when not armed.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            latch_q <= 1'b0;
        end else if (!edge_armed) begin
            latch_q <= 1'b0;
        end else if (fall_det) begin
            latch_q <= 1'b1;
        end else if (ack) begin
            latch_q <= 1'b0;
        end
    end

    // Pending and status follow the mode-dependent source selection.
    always_comb begin
        if (edge_armed) begin
            pend   = latch_q;
            status = latch_q;
        end else begin
            pend   = enabled && pin_low;
            status = pin_low;
        end
    end

endmodule

// File: rtl/irq_cfg_reg.sv
// Module: irq_cfg_reg
// Writable part of the priority register: level fields and trigger modes.
// Assumes the slot layout from irq_ctrl_pkg. Internal fields sit above the external slots.
module irq_cfg_reg
    import irq_ctrl_pkg::*;
#(
    parameter int N_EXT = 3,
    parameter int N_INT = 2,
    localparam int REG_W = N_EXT * SLOT_W + N_INT * LVL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_rst,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    output logic [N_EXT*LVL_W-1:0] ext_lvl,
    output logic [N_EXT-1:0]       ext_mode,
    output logic [N_INT*LVL_W-1:0] int_lvl
);

    localparam int INT_BASE = N_EXT * SLOT_W;

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        // Capture one external pin's level field and mode bit.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst) begin
                ext_lvl[i*LVL_W +: LVL_W] <= '0;
                ext_mode[i]               <= 1'b0;
            end else if (wr_en) begin
                ext_lvl[i*LVL_W +: LVL_W] <= wr_data[i*SLOT_W +: LVL_W];
                ext_mode[i]               <= wr_data[i*SLOT_W + SLOT_MODE_BIT];
            end
        end
    end

    for (genvar j = 0; j < N_INT; j++) begin : g_int
        // Capture one internal source's level field.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst) begin
                int_lvl[j*LVL_W +: LVL_W] <= '0;
            end else if (wr_en) begin
                int_lvl[j*LVL_W +: LVL_W] <= wr_data[INT_BASE + j*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/ext_irq_prio_ctrl.sv
// Module: ext_irq_prio_ctrl
// Top level: configuration register, external pin channels, internal-source
// qualification, read-back assembly and priority outputs.
// Assumes int_req is synchronous to clk. Sources are ordered externals first,
// then the internal ones.
module ext_irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_EXT       = 3,
    parameter int N_INT       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int N_SRC = N_EXT + N_INT,
    localparam int REG_W = N_EXT * SLOT_W + N_INT * LVL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_rst,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    output logic [REG_W-1:0]       rd_data,
    input  logic [N_EXT-1:0]       irq_pin_n,
    input  logic [N_EXT-1:0]       ack_ext,
    input  logic [N_INT-1:0]       int_req,
    output logic [N_SRC-1:0]       pend,
    output logic [N_SRC*LVL_W-1:0] prio_lvl
);

    localparam int INT_BASE = N_EXT * SLOT_W;

    logic [N_EXT*LVL_W-1:0] ext_lvl;
    logic [N_EXT-1:0]       ext_mode;
    logic [N_INT*LVL_W-1:0] int_lvl;
    logic [N_EXT-1:0]       ext_stat;
    logic [N_SRC*LVL_W-1:0] all_lvl;

    irq_cfg_reg #(
        .N_EXT(N_EXT),
        .N_INT(N_INT)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ext_lvl (ext_lvl),
        .ext_mode(ext_mode),
        .int_lvl (int_lvl)
    );

    for (genvar i = 0; i < N_EXT; i++) begin : g_chan
        irq_ext_chan #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .pin_n  (irq_pin_n[i]),
            .lvl_fld(ext_lvl[i*LVL_W +: LVL_W]),
            .mode   (trig_mode_e'(ext_mode[i])),
            .ack    (ack_ext[i]),
            .pend   (pend[i]),
            .status (ext_stat[i])
        );
    end

    for (genvar j = 0; j < N_INT; j++) begin : g_int
        // Internal source qualifies its request with its enable field.
        assign pend[N_EXT + j] = int_req[j] && (int_lvl[j*LVL_W +: LVL_W] != '0);
    end

    assign all_lvl = {int_lvl, ext_lvl};

    for (genvar k = 0; k < N_SRC; k++) begin : g_prio
        // Priority output is the decoded level while pending, zero otherwise.
        assign prio_lvl[k*LVL_W +: LVL_W] =
            pend[k] ? field_to_prio(all_lvl[k*LVL_W +: LVL_W]) : '0;
    end

    // Assemble the read word from stored fields and live status bits.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_EXT; i++) begin
            rd_data[i*SLOT_W +: LVL_W]          = ext_lvl[i*LVL_W +: LVL_W];
            rd_data[i*SLOT_W + SLOT_MODE_BIT]   = ext_mode[i];
            rd_data[i*SLOT_W + SLOT_STAT_BIT]   = ext_stat[i];
        end
        for (int j = 0; j < N_INT; j++) begin
            rd_data[INT_BASE + j*LVL_W +: LVL_W] = int_lvl[j*LVL_W +: LVL_W];
        end
    end

endmodule

// File: rtl/irq_prio_chk.sv
// Module: irq_prio_chk
// Assertion checker bound to ext_irq_prio_ctrl. It observes ports only.
// Assumes the slot layout from irq_ctrl_pkg.
module irq_prio_chk
    import irq_ctrl_pkg::*;
#(
    parameter int N_EXT = 3,
    parameter int N_INT = 2,
    localparam int N_SRC = N_EXT + N_INT,
    localparam int REG_W = N_EXT * SLOT_W + N_INT * LVL_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sw_rst,
    input logic [REG_W-1:0]       rd_data,
    input logic [N_INT-1:0]       int_req,
    input logic [N_SRC-1:0]       pend,
    input logic [N_SRC*LVL_W-1:0] prio_lvl
);

    localparam int INT_BASE = N_EXT * SLOT_W;

    // R2
    sw_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (pend == '0));

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        // R10
        disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[i*SLOT_W +: LVL_W] == '0) |-> !pend[i]);
        // R7
        edge_status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[i*SLOT_W + SLOT_MODE_BIT] && rd_data[i*SLOT_W +: LVL_W] != '0)
            |-> (pend[i] == rd_data[i*SLOT_W + SLOT_STAT_BIT]));
    end

    for (genvar j = 0; j < N_INT; j++) begin : g_int
        // R11
        int_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend[N_EXT + j] == (int_req[j] && rd_data[INT_BASE + j*LVL_W +: LVL_W] != '0));
    end

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        // R12
        idle_prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pend[k] |-> (prio_lvl[k*LVL_W +: LVL_W] == '0));
        // R3
        prio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            prio_lvl[k*LVL_W +: LVL_W] != 2'd3);
    end

endmodule

bind ext_irq_prio_ctrl irq_prio_chk #(
    .N_EXT(N_EXT),
    .N_INT(N_INT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_rst  (sw_rst),
    .rd_data (rd_data),
    .int_req (int_req),
    .pend    (pend),
    .prio_lvl(prio_lvl)
);

// File: tb/ext_irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [2:0]  irq_pin_n = 3'b111;
    logic [2:0]  ack_ext = '0;
    logic [1:0]  int_req = '0;
    logic [4:0]  pend;
    logic [9:0]  prio_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_prio_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_pin_n(irq_pin_n),
        .ack_ext  (ack_ext),
        .int_req  (int_req),
        .pend     (pend),
        .prio_lvl (prio_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [15:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        cyc(1);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_ack(input int c);
        ack_ext[c] = 1'b1;
        cyc(1);
        ack_ext[c] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 pend", pend, 0);
        chk("R1 prio", prio_lvl, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 rd_data after release", rd_data, 0);

        // Sweep: every external pin x mode x level field.
        for (int c = 0; c < 3; c++) begin
            for (int m = 0; m < 2; m++) begin
                for (int l = 0; l < 4; l++) begin
                    logic [15:0] cfg;
                    logic        en;
                    en  = (l != 0);
                    cfg = 16'((l << (4*c)) | (m << (4*c+2)) | (1 << (4*c+3)));
                    write_reg(cfg);
                    // R4 field read-back, R5 status bit ignores the written 1
                    chk($sformatf("R4 c%0d m%0d l%0d readback", c, m, l),
                        rd_data[4*c +: 3], 32'((m << 2) | l));
                    chk($sformatf("R5 c%0d m%0d l%0d status", c, m, l), rd_data[4*c+3], 0);
                    irq_pin_n[c] = 1'b0;
                    cyc(4);
                    // R6/R7/R10: pin low
                    chk($sformatf("R6 R7 R10 c%0d m%0d l%0d pend low", c, m, l), pend, 32'(en) << c);
                    chk($sformatf("R3 c%0d m%0d l%0d prio", c, m, l),
                        prio_lvl, en ? 32'(l - 1) << (2*c) : 0);
                    chk($sformatf("R6 R10 c%0d m%0d l%0d status low", c, m, l), rd_data[4*c+3], 1);
                    irq_pin_n[c] = 1'b1;
                    cyc(4);
                    // R7 latch holds in edge mode; R6 clears in level mode
                    chk($sformatf("R6 R7 c%0d m%0d l%0d pend high", c, m, l),
                        pend, 32'(en && m == 1) << c);
                    chk($sformatf("R7 R10 c%0d m%0d l%0d status high", c, m, l),
                        rd_data[4*c+3], 32'(en && m == 1));
                    chk($sformatf("R12 c%0d m%0d l%0d prio high", c, m, l),
                        prio_lvl, (en && m == 1) ? 32'(l - 1) << (2*c) : 0);
                    pulse_ack(c);
                    // R8 acknowledge clears the latch
                    chk($sformatf("R8 c%0d m%0d l%0d pend after ack", c, m, l), pend, 0);
                end
            end
        end

        // R8: acknowledge coinciding with a new detected edge keeps the latch set.
        write_reg(16'h0060);
        irq_pin_n[1] = 1'b0; cyc(4);
        irq_pin_n[1] = 1'b1; cyc(4);
        chk("R8 latch armed", pend, 5'b00010);
        irq_pin_n[1] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        ack_ext[1] = 1'b1;
        cyc(1);
        ack_ext[1] = 1'b0;
        chk("R8 set wins over ack", pend, 5'b00010);
        irq_pin_n[1] = 1'b1; cyc(4);
        pulse_ack(1);
        chk("R8 cleared later", pend, 0);

        // R9: switching to level mode or disabling drops the latch.
        write_reg(16'h0700);
        irq_pin_n[2] = 1'b0; cyc(4);
        irq_pin_n[2] = 1'b1; cyc(4);
        chk("R9 latch set", pend, 5'b00100);
        write_reg(16'h0300);
        chk("R9 level mode clears", pend, 0);
        write_reg(16'h0700); cyc(1);
        chk("R9 edge re-enable stays clear", pend, 0);
        chk("R9 status clear", rd_data[11], 0);
        irq_pin_n[2] = 1'b0; cyc(4);
        irq_pin_n[2] = 1'b1; cyc(4);
        write_reg(16'h0400);
        chk("R9 disable clears", pend, 0);
        write_reg(16'h0700); cyc(1);
        chk("R9 re-enable after disable stays clear", pend, 0);

        // R11: internal sources, every level x request.
        for (int j = 0; j < 2; j++) begin
            for (int l = 0; l < 4; l++) begin
                for (int r = 0; r < 2; r++) begin
                    write_reg(16'(l << (12 + 2*j)));
                    int_req = 2'(r << j);
                    #1;
                    chk($sformatf("R11 src%0d l%0d r%0d pend", j, l, r),
                        pend, 32'(r == 1 && l != 0) << (3 + j));
                    chk($sformatf("R3 R12 src%0d l%0d r%0d prio", j, l, r), prio_lvl,
                        (r == 1 && l != 0) ? 32'(l - 1) << (2*(3 + j)) : 0);
                    chk($sformatf("R4 src%0d l%0d readback", j, l),
                        rd_data[12 + 2*j +: 2], 32'(l));
                    cyc(1);
                end
            end
        end
        int_req = '0;

        // R2: software reset clears everything and beats a simultaneous write.
        write_reg(16'hF777);
        irq_pin_n[0] = 1'b0; int_req = 2'b11; cyc(4);
        chk("R2 pre pend", pend, 5'b11001);
        sw_rst = 1'b1; wr_en = 1'b1; wr_data = 16'hF777;
        cyc(1);
        sw_rst = 1'b0; wr_en = 1'b0;
        chk("R2 fields cleared", rd_data & 16'hF777, 0);
        chk("R2 pend cleared", pend, 0);
        chk("R2 R10 status shows pin", rd_data[3], 1);
        irq_pin_n[0] = 1'b1; int_req = '0; cyc(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule